// File: doc/BRIEF.md
# Single-Wire Framed Word Link

This block moves fixed-width parallel words across one serial wire, for example a single vertical connection between two stacked dies where wires are expensive. Words arrive on a valid/ready input and wait in a small queue. A shifter takes each word and sends it as a frame of DATA_W+2 bit periods. A receiver on the far end of the wire rebuilds the word and raises a strobe for one cycle. No clock or strobe travels with the data. Each frame carries its own start edge, and the receiver stops by counting bits.

A frame is a start bit of 1, then the DATA_W data bits least significant first, then a stop bit of 0. The wire rests at 0 when nothing is being sent, so every start bit is a rising edge. Both ends share one synchronous clock. The serial wire is brought out on a port so that it can be observed.

Top module: `zlink_top`

## Requirements
- R1: While reset is applied and in the first cycle after it, `line_out` and `out_valid` are 0 and `in_ready` is 1.
- R2: Each frame on `line_out` holds one bit per cycle: a start bit 1, then `in_data` bits 0 to DATA_W-1, then a stop bit 0. The stop bit is on the wire in the cycle where `out_valid` is high.
- R3: With the link idle, a word accepted on clock edge A puts its start bit on the wire after edge A+1, and `out_valid` rises after edge A+DATA_W+2.
- R4: When the queue holds further words, frames follow back to back, and successive `out_valid` pulses are exactly DATA_W+2 cycles apart.
- R5: The receiver leaves idle only on a 0-to-1 change of the wire. It raises `out_valid` for exactly one cycle per frame, and `out_data` holds the words in the order they were accepted.
- R6: A word is accepted only on an edge where `in_valid` and `in_ready` are both 1. `in_ready` falls when QDEPTH words are queued. While `in_valid` is 0, `in_data` has no effect on the wire or the outputs.
- R7: When the queue is empty at the end of a frame, `line_out` stays 0 until another word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ends |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source offers a word |
| in_data | input | DATA_W | Word offered |
| in_ready | output | 1 | Queue can take a word |
| line_out | output | 1 | Serial wire, observable |
| out_valid | output | 1 | One-cycle strobe for a received word |
| out_data | output | DATA_W | Received word |

## Verification
The assertions assume that the only rising edges the receiver sees while idle are genuine start bits. They also assume that `in_valid` and `in_data` are driven cleanly between clock edges. Both hold because the wire is driven only by the block's own shifter. The stimulus changes its inputs on falling edges only and holds a word until `in_ready` lets it through. This keeps every accepted word in the expected list, in order, so the data check against `out_data` can rely on acceptance order.

// File: rtl/zlink_pkg.sv
package zlink_pkg;
  typedef enum logic {PH_IDLE, PH_RUN} phase_t;
endpackage

// File: rtl/zlink_queue.sv
module zlink_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [W-1:0]                 wr_data,
  input  logic                         rd_en,
  output logic [W-1:0]                 rd_data,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_wr, do_rd;

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      if (do_wr && !do_rd)      level <= level + 1'b1;
      else if (do_rd && !do_wr) level <= level - 1'b1;
    end
  end
endmodule

// File: rtl/zlink_ser.sv
module zlink_ser
  import zlink_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              have_word,
  input  logic [DATA_W-1:0] word,
  output logic              take,
  output logic              line,
  output logic              busy
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  phase_t             ph;
  logic [FRAME_W-1:0] sr;
  logic [CNT_W-1:0]   cnt;
  logic               at_end;

  assign at_end = (ph == PH_RUN) && (cnt == LAST);
  assign take   = have_word && ((ph == PH_IDLE) || at_end);
  assign line   = sr[0];
  assign busy   = (ph == PH_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= PH_IDLE;
      sr  <= '0;
      cnt <= '0;
    end else if (take) begin
      sr  <= {1'b0, word, 1'b1};
      cnt <= '0;
      ph  <= PH_RUN;
    end else if (at_end) begin
      sr  <= '0;
      cnt <= '0;
      ph  <= PH_IDLE;
    end else if (ph == PH_RUN) begin
      sr  <= sr >> 1;
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/zlink_des.sv
module zlink_des
  import zlink_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line,
  output logic [DATA_W-1:0] word,
  output logic              valid,
  output logic              busy
);
  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] LASTBIT = CW'(DATA_W - 1);

  phase_t            ph;
  logic              prev;
  logic [DATA_W-1:0] sh;
  logic [CW-1:0]     cnt;

  assign busy = (ph == PH_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_IDLE;
      prev  <= 1'b0;
      sh    <= '0;
      cnt   <= '0;
      word  <= '0;
      valid <= 1'b0;
    end else begin
      prev  <= line;
      valid <= 1'b0;
      if (ph == PH_IDLE) begin
        if (line && !prev) begin
          ph  <= PH_RUN;
          cnt <= '0;
        end
      end else begin
        sh <= {line, sh[DATA_W-1:1]};
        if (cnt == LASTBIT) begin
          word  <= {line, sh[DATA_W-1:1]};
          valid <= 1'b1;
          ph    <= PH_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/zlink_top.sv
module zlink_top #(
  parameter int DATA_W = 8,
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              line_out,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int LW = $clog2(QDEPTH + 1);

  logic              q_empty, q_full, q_take;
  logic [DATA_W-1:0] q_head;
  logic [LW-1:0]     q_level;
  logic              tx_busy, rx_busy;

  assign in_ready = !q_full;

  zlink_queue #(.W(DATA_W), .DEPTH(QDEPTH)) i_queue (
    .clk(clk), .rst(rst),
    .wr_en(in_valid), .wr_data(in_data),
    .rd_en(q_take), .rd_data(q_head),
    .empty(q_empty), .full(q_full), .level(q_level)
  );

  zlink_ser #(.DATA_W(DATA_W)) i_ser (
    .clk(clk), .rst(rst),
    .have_word(!q_empty), .word(q_head), .take(q_take),
    .line(line_out), .busy(tx_busy)
  );

  zlink_des #(.DATA_W(DATA_W)) i_des (
    .clk(clk), .rst(rst),
    .line(line_out), .word(out_data), .valid(out_valid), .busy(rx_busy)
  );
endmodule

// File: rtl/zlink_chk.sv
module zlink_chk #(
  parameter int DATA_W = 8,
  parameter int QDEPTH = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic                       line_out,
  input logic                       out_valid,
  input logic [$clog2(QDEPTH+1)-1:0] q_level,
  input logic                       tx_busy,
  input logic                       rx_busy
);
  AST_STOP_BIT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !line_out); // R2
  AST_QUEUE_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (q_level != '0 && !tx_busy) |=> tx_busy); // R3
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R5
  AST_WAKE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    ($rose(line_out) && !rx_busy) |=> rx_busy); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (q_level != '0)); // R6
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> !line_out); // R7
endmodule

bind zlink_top zlink_chk #(.DATA_W(DATA_W), .QDEPTH(QDEPTH)) i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .line_out(line_out), .out_valid(out_valid), .q_level(q_level),
  .tx_busy(tx_busy), .rx_busy(rx_busy)
);

// File: tb/test_zlink_top.sv
`timescale 1ns/1ps
module test_zlink_top;
  localparam int N  = 8;
  localparam int D  = 4;
  localparam int FW = N + 2;
  localparam int NV = 8;
  localparam logic [N-1:0] VW [NV] = '{8'h3C, 8'h81, 8'hFF, 8'h00, 8'h5A, 8'h01, 8'h80, 8'hC3};
  localparam int           VG [NV] = '{0, 0, 3, 0, 12, 1, 0, 20};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [N-1:0] in_data = '0;
  logic in_ready, line_out, out_valid;
  logic [N-1:0] out_data;

  always #2 clk = ~clk;

  zlink_top #(.DATA_W(N), .QDEPTH(D)) i_zlink_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .line_out(line_out), .out_valid(out_valid), .out_data(out_data)
  );

  int cyc = 0;
  int checks = 0, fails = 0;
  int wr_n = 0, rd_n = 0;
  logic [N-1:0] expw [256];
  int vcyc [256];
  bit saw_full = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // R5: received words in acceptance order
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      chk(out_data == expw[rd_n], "R5 word order/data", out_data, expw[rd_n]);
      vcyc[rd_n] = cyc;
      rd_n++;
    end
  end

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic send_word(input logic [N-1:0] w);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) begin
      saw_full = 1;
      @(negedge clk);
    end
    @(posedge clk);
    expw[wr_n] = w;
    wr_n++;
    @(negedge clk);
  endtask

  task automatic drain();
    for (int t = 0; t < 40 * FW && rd_n != wr_n; t++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R5 actual=%0d expected=%0d", rd_n, wr_n);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(line_out == 0 && out_valid == 0 && in_ready == 1, "R1 during reset", {line_out, out_valid, in_ready}, 3'b001);
    rst = 1'b0;
    @(negedge clk);
    chk(line_out == 0 && out_valid == 0 && in_ready == 1, "R1 after reset", {line_out, out_valid, in_ready}, 3'b001);

    // frame shape and latency from an idle link
    begin
      logic [N-1:0] w;
      int a;
      w = 8'hA5;
      send_word(w);
      in_valid = 1'b0;
      a = cyc;
      for (int k = 1; k <= FW; k++) begin
        logic eb;
        @(negedge clk);
        eb = (k == 1) ? 1'b1 : (k == FW) ? 1'b0 : w[k-2];
        chk(line_out == eb, "R2 frame bit", line_out, eb);
        chk(out_valid == (k == FW), "R3 strobe timing", out_valid, (k == FW));
      end
      chk(cyc == a + N + 2, "R3 latency", cyc - a, N + 2);
    end
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(line_out == 0, "R7 idle line", line_out, 0);
    end

    // back-to-back frames
    begin
      int base;
      base = wr_n;
      send_word(8'h11);
      send_word(8'h22);
      send_word(8'h33);
      in_valid = 1'b0;
      drain();
      chk(vcyc[base+1] - vcyc[base] == FW, "R4 spacing 1", vcyc[base+1] - vcyc[base], FW);
      chk(vcyc[base+2] - vcyc[base+1] == FW, "R4 spacing 2", vcyc[base+2] - vcyc[base+1], FW);
    end

    // queue fills and back-pressures
    saw_full = 0;
    for (int i = 0; i < D + 2; i++) send_word(N'(8'h40 + i));
    in_valid = 1'b0;
    chk(saw_full, "R6 in_ready low when full", saw_full, 1);
    drain();
    chk(rd_n == wr_n, "R6 no word lost", rd_n, wr_n);

    // in_data ignored while in_valid low
    begin
      int r0;
      r0 = rd_n;
      for (int k = 0; k < 3 * FW; k++) begin
        in_data = N'(k * 37);
        @(negedge clk);
        if (line_out != 0) chk(0, "R6 idle wire", line_out, 0);
      end
      chk(rd_n == r0 && line_out == 0, "R6 no effect without in_valid", rd_n, r0);
    end

    // table of words with gaps
    for (int i = 0; i < NV; i++) begin
      repeat (VG[i]) @(negedge clk);
      send_word(VW[i]);
      in_valid = 1'b0;
    end
    drain();
    chk(rd_n == wr_n, "R5 all table words received", rd_n, wr_n);
    chk(line_out == 0 && in_ready == 1, "R7 rest after table", {line_out, in_ready}, 2'b01);
    report();
  end
endmodule